// File: doc/BRIEF.md
# Indirect I/O Memory Window Bridge

The bridge is an I/O-port slave that gives a host with a narrow, byte-wide I/O bus access to a 32-bit memory space. It decodes five consecutive ports starting at a programmable 16-bit base. The first four ports are byte registers that together form the memory address. The fifth port is a data port. Writing it sends a one-byte memory write to that address. Reading it fetches one byte from that address and returns it to the host.

The address is never advanced by a data-port access. A host can therefore set the upper address bytes once and change only the low bytes afterwards. It can also treat the data port as a streaming window onto one fixed location. The base address arrives as two separate bytes, high and low, from configuration logic outside the block.

On the memory side the block is a single-outstanding request/acknowledge master. While a data-port transaction is waiting for its acknowledge, the host-side ready signal is held low.

Top module: `iowin_bridge`

## Requirements
- R1: An I/O strobe hits the window when the 16-bit modular difference between `io_addr_i` and the base `{io_base_hi_i, io_base_lo_i}` is 0 to 4. That difference is the port offset.
- R2: A write to offset k (0 to 3) loads `mem_addr_o` bits 8k+7:8k from the edge that samples it. The other three bytes keep their values.
- R3: A read of offset k (0 to 3) drives `io_rdata_o` with address byte k and holds `io_rdata_oe_o` high for exactly the cycle after the strobe edge.
- R4: A write to offset 4 raises `mem_req_o` with `mem_we_o`=1 in the cycle after the strobe. `mem_wdata_o` carries the written byte and `mem_addr_o` the assembled address. Exactly one memory write is performed.
- R5: A read of offset 4 raises `mem_req_o` with `mem_we_o`=0. In the cycle after the edge that samples `mem_ack_i`, `io_rdata_o` equals the `mem_rdata_i` sampled there and `io_rdata_oe_o` is high for that one cycle.
- R6: `io_ready_o` is low from the cycle after a data-port strobe until the cycle after the acknowledge. It is high at all other times, and never high while `mem_req_o` is high.
- R7: A data-port access leaves the address unchanged. Repeated accesses go to the same location.
- R8: Strobes outside the window change no state, raise no memory request and leave `io_rdata_oe_o` low.
- R9: Strobes that arrive while `io_ready_o` is low are ignored.
- R10: After reset the address is 0, `mem_req_o` is 0, `io_rdata_oe_o` is 0 and `io_ready_o` is 1.
- R11: While `mem_req_o` is high and no acknowledge has been sampled, the request, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_base_hi_i | input | 8 | High byte of the I/O window base |
| io_base_lo_i | input | 8 | Low byte of the I/O window base |
| io_addr_i | input | 16 | Host I/O address |
| io_wr_i | input | 1 | Host write strobe, one cycle |
| io_rd_i | input | 1 | Host read strobe, one cycle |
| io_wdata_i | input | 8 | Host write data |
| io_rdata_o | output | 8 | Read return data |
| io_rdata_oe_o | output | 1 | Read data valid and bus drive enable |
| io_ready_o | output | 1 | Bridge can accept a strobe |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | 8 | Memory read data, valid with acknowledge |

## Verification
The bench targets these corner cases:
- **Partial address update.** It rewrites only offset 1 and then reads the data port. A bridge that reset or shifted the other bytes would fetch from the wrong location.
- **Repeated data-port access.** It issues back-to-back data-port reads and writes and checks that the memory address stays fixed. An auto-incrementing bridge would drift.
- **Edges of the window.** It strobes at base-1 and base+5. A decoder with an off-by-one bound would alter an address byte or start a stray memory cycle.
- **Strobe while busy.** It sends a write during a slow memory read. A bridge that accepted it would corrupt the address mid-transaction.
- **Variable latency.** Acknowledge latency varies from zero to three cycles, which exposes a read path that returns data one cycle early or late.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } iowin_state_e;
endpackage

// File: rtl/iowin_decode.sv
module iowin_decode #(
  parameter int IO_AW = 16,
  parameter int NB    = 4,
  parameter int OFF_W = 3
) (
  input  logic [IO_AW/2-1:0] base_hi_i,
  input  logic [IO_AW/2-1:0] base_lo_i,
  input  logic [IO_AW-1:0]   io_addr_i,
  output logic               hit_o,
  output logic               data_sel_o,
  output logic [NB-1:0]      byte_sel_o,
  output logic [OFF_W-1:0]   off_o
);
  localparam logic [IO_AW-1:0] DATA_OFF = IO_AW'(NB);

  logic [IO_AW-1:0] delta;

  // modular difference; window is base..base+NB
  assign delta      = io_addr_i - {base_hi_i, base_lo_i};
  assign hit_o      = (delta <= DATA_OFF);
  assign data_sel_o = (delta == DATA_OFF);
  assign off_o      = delta[OFF_W-1:0];

  for (genvar i = 0; i < NB; i++) begin : g_sel
    assign byte_sel_o[i] = (delta == IO_AW'(i));
  end
endmodule

// File: rtl/iowin_addr_regs.sv
module iowin_addr_regs #(
  parameter int DW    = 8,
  parameter int NB    = 4,
  parameter int OFF_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [NB-1:0]    byte_sel_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [OFF_W-1:0] rd_off_i,
  output logic [NB*DW-1:0] addr_o,
  output logic [DW-1:0]    rdata_o
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_o[i*DW +: DW] <= '0;
      end else if (wr_en_i && byte_sel_i[i]) begin
        addr_o[i*DW +: DW] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (rd_off_i == OFF_W'(i)) rdata_o = addr_o[i*DW +: DW];
    end
  end
endmodule

// File: rtl/iowin_xfer_ctrl.sv
module iowin_xfer_ctrl
  import iowin_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_wr_i,
  input  logic          start_rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          rd_done_o,
  output logic          busy_o
);
  iowin_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_wr_i)      state_d = ST_WR;
        else if (start_rd_i) state_d = ST_RD;
      end
      ST_WR, ST_RD: begin
        if (ack_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wdata_o <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_wr_i) wdata_o <= wdata_i;
    end
  end

  assign req_o     = (state_q != ST_IDLE);
  assign we_o      = (state_q == ST_WR);
  assign busy_o    = req_o;
  assign rd_done_o = (state_q == ST_RD) && ack_i;
endmodule

// File: rtl/iowin_bridge.sv
module iowin_bridge #(
  parameter int IO_AW  = 16,
  parameter int MEM_AW = 32,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IO_AW/2-1:0] io_base_hi_i,
  input  logic [IO_AW/2-1:0] io_base_lo_i,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [DW-1:0]     io_wdata_i,
  output logic [DW-1:0]     io_rdata_o,
  output logic              io_rdata_oe_o,
  output logic              io_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  localparam int NB    = MEM_AW / DW;
  localparam int OFF_W = $clog2(NB + 1);

  logic             hit, data_sel, busy, rd_done;
  logic [NB-1:0]    byte_sel;
  logic [OFF_W-1:0] off;
  logic [DW-1:0]    reg_rdata;
  logic             acc_wr, acc_rd;
  logic [DW-1:0]    rdata_q;
  logic             oe_q;

  // write wins if both strobes arrive together
  assign acc_wr = io_wr_i && !busy && hit;
  assign acc_rd = io_rd_i && !io_wr_i && !busy && hit;

  iowin_decode #(.IO_AW(IO_AW), .NB(NB), .OFF_W(OFF_W)) u_decode (
    .base_hi_i  (io_base_hi_i),
    .base_lo_i  (io_base_lo_i),
    .io_addr_i  (io_addr_i),
    .hit_o      (hit),
    .data_sel_o (data_sel),
    .byte_sel_o (byte_sel),
    .off_o      (off)
  );

  iowin_addr_regs #(.DW(DW), .NB(NB), .OFF_W(OFF_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (acc_wr),
    .byte_sel_i (byte_sel),
    .wdata_i    (io_wdata_i),
    .rd_off_i   (off),
    .addr_o     (mem_addr_o),
    .rdata_o    (reg_rdata)
  );

  iowin_xfer_ctrl #(.DW(DW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_wr_i (acc_wr && data_sel),
    .start_rd_i (acc_rd && data_sel),
    .wdata_i    (io_wdata_i),
    .ack_i      (mem_ack_i),
    .req_o      (mem_req_o),
    .we_o       (mem_we_o),
    .wdata_o    (mem_wdata_o),
    .rd_done_o  (rd_done),
    .busy_o     (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= rd_done || (acc_rd && !data_sel);
      if (rd_done)                   rdata_q <= mem_rdata_i;
      else if (acc_rd && !data_sel)  rdata_q <= reg_rdata;
    end
  end

  assign io_rdata_o    = rdata_q;
  assign io_rdata_oe_o = oe_q;
  assign io_ready_o    = !busy;
endmodule

// File: rtl/iowin_bridge_chk.sv
module iowin_bridge_chk #(
  parameter int IO_AW  = 16,
  parameter int MEM_AW = 32,
  parameter int DW     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IO_AW/2-1:0] io_base_hi_i,
  input logic [IO_AW/2-1:0] io_base_lo_i,
  input logic [IO_AW-1:0]  io_addr_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [DW-1:0]     io_wdata_i,
  input logic [DW-1:0]     io_rdata_o,
  input logic              io_rdata_oe_o,
  input logic              io_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic [DW-1:0]     mem_wdata_o,
  input logic              mem_ack_i,
  input logic [DW-1:0]     mem_rdata_i
);
  localparam logic [IO_AW-1:0] DPORT = IO_AW'(MEM_AW / DW);

  logic [IO_AW-1:0] rel;
  assign rel = io_addr_i - {io_base_hi_i, io_base_lo_i};

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o) &&
      $stable(mem_addr_o) && $stable(mem_wdata_o));

  assert_busy_not_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !io_ready_o);

  assert_rd_return_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i |=>
      io_rdata_oe_o && io_ready_o && io_rdata_o == $past(mem_rdata_i));

  assert_wr_issue_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ready_o && io_wr_i && rel == DPORT |=>
      mem_req_o && mem_we_o && mem_wdata_o == $past(io_wdata_i));

  assert_miss_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ready_o && (io_wr_i || io_rd_i) && rel > DPORT |=>
      !io_rdata_oe_o && !mem_req_o && $stable(mem_addr_o));

  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_ready_o && io_wr_i |=> $stable(mem_addr_o));

  assert_no_incr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> $stable(mem_addr_o));
endmodule

bind iowin_bridge iowin_bridge_chk #(.IO_AW(IO_AW), .MEM_AW(MEM_AW), .DW(DW)) u_chk (.*);

// File: tb/iowin_bridge_test.sv
module iowin_bridge_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  io_base_hi_i = 8'h00, io_base_lo_i = 8'h00;
  logic [15:0] io_addr_i = '0;
  logic        io_wr_i = 1'b0, io_rd_i = 1'b0;
  logic [7:0]  io_wdata_i = '0;
  logic [7:0]  io_rdata_o;
  logic        io_rdata_oe_o, io_ready_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;

  int checks = 0;
  int errors = 0;

  iowin_bridge uut (.*);

  always #5 clk_i = ~clk_i;

  // memory model
  int          wcount = 0;
  logic [31:0] last_waddr = '0;
  logic [7:0]  last_wdata = '0;
  int          lat = 0, lat_cnt = 0;
  bit          slow = 1'b0;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5a;
  endfunction

  always @(posedge clk_i) begin
    mem_ack_i <= 1'b0;
    if (mem_req_o && !mem_ack_i) begin
      if (lat_cnt >= lat) begin
        mem_ack_i   <= 1'b1;
        mem_rdata_i <= mem_byte(mem_addr_o);
        if (mem_we_o) begin
          wcount     <= wcount + 1;
          last_waddr <= mem_addr_o;
          last_wdata <= mem_wdata_o;
        end
        lat_cnt <= 0;
        lat     <= slow ? 3 : int'($urandom % 4);
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // bench model of the address
  logic [7:0] exp_b [4];

  function automatic logic [31:0] exp_addr();
    return {exp_b[3], exp_b[2], exp_b[1], exp_b[0]};
  endfunction

  function automatic logic [15:0] base();
    return {io_base_hi_i, io_base_lo_i};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!io_ready_o) @(negedge clk_i);
  endtask

  task automatic strobe(input logic [15:0] a, input bit wr, input logic [7:0] d);
    @(negedge clk_i);
    io_addr_i = a; io_wdata_i = d; io_wr_i = wr; io_rd_i = !wr;
    @(negedge clk_i);
    io_wr_i = 1'b0; io_rd_i = 1'b0;
  endtask

  task automatic wr_op(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] rel;
    int          c0;
    rel = a - base();
    c0  = wcount;
    strobe(a, 1'b1, d);
    if (rel < 4) begin
      exp_b[rel[1:0]] = d;
      chk("R2 addr byte write", mem_addr_o, exp_addr());
      chk("R2 no req", {31'd0, mem_req_o}, 32'd0);
    end else if (rel == 4) begin
      chk("R4 req/we", {30'd0, mem_req_o, mem_we_o}, 32'd3);
      chk("R4 wdata", {24'd0, mem_wdata_o}, {24'd0, d});
      chk("R6 ready low", {31'd0, io_ready_o}, 32'd0);
      wait_ready();
      chk("R4 one write", wcount, c0 + 1);
      chk("R4 write addr", last_waddr, exp_addr());
      chk("R4 write data", {24'd0, last_wdata}, {24'd0, d});
      chk("R7 addr kept", mem_addr_o, exp_addr());
    end else begin
      chk("R8 miss quiet", {30'd0, mem_req_o, io_rdata_oe_o}, 32'd0);
      chk("R8 addr kept", mem_addr_o, exp_addr());
    end
  endtask

  task automatic rd_op(input logic [15:0] a);
    logic [15:0] rel;
    rel = a - base();
    strobe(a, 1'b0, 8'h00);
    if (rel < 4) begin
      chk("R3 readback oe", {31'd0, io_rdata_oe_o}, 32'd1);
      chk("R3 readback data", {24'd0, io_rdata_o}, {24'd0, exp_b[rel[1:0]]});
      @(negedge clk_i);
      chk("R3 oe one cycle", {31'd0, io_rdata_oe_o}, 32'd0);
    end else if (rel == 4) begin
      chk("R5 req read", {30'd0, mem_req_o, mem_we_o}, 32'd2);
      chk("R7 read addr", mem_addr_o, exp_addr());
      chk("R6 ready low", {31'd0, io_ready_o}, 32'd0);
      wait_ready();
      chk("R5 data oe", {31'd0, io_rdata_oe_o}, 32'd1);
      chk("R5 data", {24'd0, io_rdata_o}, {24'd0, mem_byte(exp_addr())});
      chk("R6 req dropped", {31'd0, mem_req_o}, 32'd0);
    end else begin
      chk("R8 miss read quiet", {30'd0, mem_req_o, io_rdata_oe_o}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    process::self().srandom(32'h1234);
    for (int i = 0; i < 4; i++) exp_b[i] = 8'h00;
    io_base_hi_i = 8'h2e; io_base_lo_i = 8'h40;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 reset addr", mem_addr_o, 32'd0);
    chk("R10 reset flags", {29'd0, mem_req_o, io_rdata_oe_o, io_ready_o}, 32'd1);

    // directed: fill address, read back, stream
    wr_op(base() + 0, 8'h00);
    wr_op(base() + 1, 8'hf0);
    wr_op(base() + 2, 8'hff);
    wr_op(base() + 3, 8'hff);
    for (int i = 0; i < 4; i++) rd_op(base() + 16'(i));
    rd_op(base() + 4);
    rd_op(base() + 4);
    wr_op(base() + 4, 8'hff);
    wr_op(base() + 4, 8'h9c);
    // only byte 1 changes
    wr_op(base() + 1, 8'hd0);
    rd_op(base() + 4);
    for (int i = 0; i < 4; i++) rd_op(base() + 16'(i));

    // window edges
    c0 = wcount;
    wr_op(base() - 1, 8'h11);
    wr_op(base() + 5, 8'h22);
    rd_op(base() + 5);
    rd_op(base() - 1);
    chk("R1 edge no mem write", wcount, c0);
    for (int i = 0; i < 4; i++) rd_op(base() + 16'(i));

    // strobe while busy (R9)
    slow = 1'b1;
    @(negedge clk_i);
    wait_ready();
    @(negedge clk_i);
    io_addr_i = base() + 4; io_rd_i = 1'b1;
    @(negedge clk_i);
    io_rd_i = 1'b0;
    io_addr_i = base(); io_wdata_i = 8'h77; io_wr_i = 1'b1;
    @(negedge clk_i);
    io_wr_i = 1'b0;
    chk("R9 busy write ignored", mem_addr_o, exp_addr());
    wait_ready();
    chk("R5 slow read data", {24'd0, io_rdata_o}, {24'd0, mem_byte(exp_addr())});
    rd_op(base());
    slow = 1'b0;

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      int sel;
      if (n % 50 == 0) begin
        @(negedge clk_i);
        io_base_hi_i = 8'(1 + $urandom % 254);
        io_base_lo_i = 8'($urandom);
      end
      sel = int'($urandom % 8);
      a = (sel == 7) ? base() - 1 : base() + 16'(sel);
      if ($urandom % 2 == 1) wr_op(a, 8'($urandom));
      else rd_op(a);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule